// File: doc/BRIEF.md
# Dual-Coding Long-Word Serial Receiver

This block receives asynchronous serial frames on a single line and accepts two line codings. With level coding, every bit holds its value for a whole bit period. With Manchester coding, every bit carries a transition at mid-period. One receiver serves both codings. It takes data words of one to `MAXB` bits (default 17) and can assemble them with the least-significant bit first or with the most-significant bit first.

The line is oversampled at `OSR` (default 16) clock cycles per bit and passes through a synchronizer first. The coding, the bit order and the word length are latched when a start bit is found, so these inputs may change while a frame is arriving. A finished frame is placed in a one-entry receive buffer together with its status:

- a Manchester coding-error flag,
- a level stop-bit error flag,
- a flag that marks a Manchester frame of the longest word length,
- the two Manchester stop-bit values.

A one-cycle read strobe releases the buffer.

Top module: `mxrx_receiver`

## Requirements
- R1: After reset, `rx_done`, `rx_overrun`, `rx_data`, `mch_ferr`, `lvl_ferr`, `len17` and `stop_vals` are all zero.
- R2: In level mode (`manch_en`=0), a frame has four parts in this order:
  - the idle line is high;
  - a low start bit follows;
  - then `word_len` data bits;
  - then one stop bit.

  Each bit is the majority of the synchronized samples 7, 8 and 9 of its 16-sample period. The received word is zero-extended in `rx_data`.
- R3: In Manchester mode (`manch_en`=1), the frame has three parts:
  - a start bit, coded as a logic 0;
  - `word_len` data bits;
  - two stop bits.

  A logic 1 is high in the first half of the period and low in the second half. A logic 0 is the inverse.
- R4: When `msb_first`=0, the first data bit received is bit 0 of `rx_data`. When `msb_first`=1, the first data bit received is bit `word_len`-1.
- R5: Timing of `rx_done`:
  - Suppose the start bit is first sampled on `rxd` at clock edge E0, and the frame spans B bit periods.
  - Then `rx_done` is first high after edge E0+16·B+1, and not before it.
  - A one-cycle `rd` pulse clears `rx_done` and `rx_overrun` at the next edge.
- R6: In Manchester mode, any bit period with equal first-half and second-half samples sets `mch_ferr` for that frame. The data value of such a bit is its first-half sample.
- R7: `len17` is 1 only for an accepted Manchester frame whose word length is `MAXB` (17). It is 0 for a Manchester frame of 16 bits and for every level frame.
- R8: For a Manchester frame, `stop_vals[0]` receives the first stop bit and `stop_vals[1]` the second. An accepted level frame leaves `stop_vals` unchanged.
- R9: `lvl_ferr` is set for an accepted level frame whose stop bit samples low. It is always 0 for Manchester frames.
- R10: If a frame completes while `rx_done` is high and `rd` is low, the frame is dropped: `rx_overrun` goes high and `rx_data` and all flags keep their values.
- R11: A start is rejected, and no frame is delivered, in either of two cases:
  - in level mode, the start bit votes high;
  - in Manchester mode, the start bit is not a valid coded 0.
- R12: `manch_en`, `msb_first` and `word_len` are captured at the start edge. Changing them during a frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, OSR cycles per bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial line, idle high |
| manch_en | input | 1 | 1: Manchester coding, 0: level coding |
| msb_first | input | 1 | 1: most-significant bit first |
| word_len | input | 5 | Data bits per frame. 0 is treated as 1, values above MAXB as MAXB |
| rd | input | 1 | Read strobe that releases the buffer |
| rx_data | output | 17 | Received word |
| rx_done | output | 1 | Buffer holds an unread frame |
| rx_overrun | output | 1 | A frame was dropped while the buffer was full |
| mch_ferr | output | 1 | Manchester coding error in the buffered frame |
| lvl_ferr | output | 1 | Level stop bit was low |
| len17 | output | 1 | Manchester frame of maximum length |
| stop_vals | output | 2 | Stop-bit values of the last Manchester frame |

## Verification
The buffered word and its flags become valid together, at edge E0+16·B+1. This delay comes from the two synchronizer stages, the start-edge register and the end-of-bit decision. The bench drives `rxd` on falling edges. It checks, on the falling edges around the due edge, that `rx_done` is still low one cycle before it and high right after it, and only then compares the data and the flags. A read clears the buffer one edge later, and the bench checks that on the next falling edge. Each rejected start is followed by a wait of several bit periods, during which `rx_done` must stay low.

// File: rtl/mxrx_pkg.sv
package mxrx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } mxrx_state_e;

    localparam int MXRX_OSR_DEF  = 16;
    localparam int MXRX_MAXB_DEF = 17;
endpackage

// File: rtl/mxrx_sync.sv
module mxrx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign dout = s_q[STAGES-1];
endmodule

// File: rtl/mxrx_bitdec.sv
module mxrx_bitdec #(
    parameter int OSR = 16,
    localparam int CNT_W = $clog2(OSR)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line,
    input  logic [CNT_W-1:0] cnt,
    output logic             lvl_bit,
    output logic             mch_bit,
    output logic             mch_bad
);
    localparam int MID = OSR / 2;
    localparam int Q1  = OSR / 4;
    localparam int Q3  = (3 * OSR) / 4;

    typedef struct packed {
        logic [2:0] vote;
        logic       half_a;
        logic       half_b;
    } smp_t;

    smp_t d, q;

    always_comb begin
        d = q;
        if (cnt == CNT_W'(MID - 1)) d.vote[0] = line;
        if (cnt == CNT_W'(MID))     d.vote[1] = line;
        if (cnt == CNT_W'(MID + 1)) d.vote[2] = line;
        if (cnt == CNT_W'(Q1))      d.half_a  = line;
        if (cnt == CNT_W'(Q3))      d.half_b  = line;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl_bit = (q.vote[0] & q.vote[1]) | (q.vote[0] & q.vote[2]) | (q.vote[1] & q.vote[2]);
    assign mch_bit = q.half_a;
    assign mch_bad = (q.half_a == q.half_b);
endmodule

// File: rtl/mxrx_receiver.sv
module mxrx_receiver
    import mxrx_pkg::*;
#(
    parameter int OSR  = MXRX_OSR_DEF,
    parameter int MAXB = MXRX_MAXB_DEF,
    localparam int CNT_W = $clog2(OSR),
    localparam int IDX_W = $clog2(MAXB + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             manch_en,
    input  logic             msb_first,
    input  logic [IDX_W-1:0] word_len,
    input  logic             rd,
    output logic [MAXB-1:0]  rx_data,
    output logic             rx_done,
    output logic             rx_overrun,
    output logic             mch_ferr,
    output logic             lvl_ferr,
    output logic             len17,
    output logic [1:0]       stop_vals
);
    typedef struct packed {
        mxrx_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             rx_prev;
        logic             f_manch;
        logic             f_msb;
        logic [IDX_W-1:0] f_len;
        logic [MAXB-1:0]  shf;
        logic             err_acc;
        logic [1:0]       stp_acc;
        logic [MAXB-1:0]  data;
        logic             done;
        logic             ovr;
        logic             mferr;
        logic             lferr;
        logic             l17;
        logic [1:0]       stp;
    } rx_state_t;

    rx_state_t d, q;

    logic             rx_s;
    logic             lvl_bit, mch_bit, mch_bad;
    logic             bit_v, bad, finish, done_eff, end_bit;
    logic [IDX_W-1:0] len_cl, pos;
    logic             fr_manch;
    logic [IDX_W-1:0] fr_len;

    mxrx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    mxrx_bitdec #(.OSR(OSR)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .line   (rx_s),
        .cnt    (q.cnt),
        .lvl_bit(lvl_bit),
        .mch_bit(mch_bit),
        .mch_bad(mch_bad)
    );

    always_comb begin
        if (word_len == '0)                 len_cl = IDX_W'(1);
        else if (word_len > IDX_W'(MAXB))   len_cl = IDX_W'(MAXB);
        else                                len_cl = word_len;
    end

    always_comb begin
        d        = q;
        d.rx_prev = rx_s;
        bit_v    = q.f_manch ? mch_bit : lvl_bit;
        bad      = q.f_manch & mch_bad;
        finish   = 1'b0;
        done_eff = q.done & ~rd;
        end_bit  = (q.cnt == CNT_W'(OSR - 1));
        pos      = q.f_msb ? (q.f_len - IDX_W'(1) - q.idx) : q.idx;
        if (rd) begin
            d.done = 1'b0;
            d.ovr  = 1'b0;
        end
        if (q.st == ST_IDLE) begin
            if (q.rx_prev & ~rx_s) begin
                d.st      = ST_START;
                d.cnt     = CNT_W'(1);
                d.idx     = '0;
                d.f_manch = manch_en;
                d.f_msb   = msb_first;
                d.f_len   = len_cl;
                d.shf     = '0;
                d.err_acc = 1'b0;
                d.stp_acc = 2'b00;
            end
        end else begin
            d.cnt = end_bit ? '0 : q.cnt + CNT_W'(1);
            if (end_bit) begin
                case (q.st)
                    ST_START: d.st = (!bit_v && !bad) ? ST_DATA : ST_IDLE;
                    ST_DATA: begin
                        d.shf[pos] = bit_v;
                        d.err_acc  = q.err_acc | bad;
                        if (q.idx == q.f_len - IDX_W'(1)) begin
                            d.st  = ST_STOP;
                            d.idx = '0;
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end
                    ST_STOP: begin
                        d.err_acc          = q.err_acc | bad;
                        d.stp_acc[q.idx[0]] = bit_v;
                        if (!q.f_manch || q.idx[0]) finish = 1'b1;
                        else                        d.idx  = q.idx + IDX_W'(1);
                    end
                    default: d.st = ST_IDLE;
                endcase
            end
        end
        if (finish) begin
            d.st = ST_IDLE;
            if (done_eff) begin
                d.ovr = 1'b1;
            end else begin
                d.done  = 1'b1;
                d.data  = q.shf;
                d.mferr = q.f_manch & (q.err_acc | bad);
                d.lferr = ~q.f_manch & ~bit_v;
                d.l17   = q.f_manch & (q.f_len == IDX_W'(MAXB));
                if (q.f_manch) d.stp = d.stp_acc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.rx_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_data    = q.data;
    assign rx_done    = q.done;
    assign rx_overrun = q.ovr;
    assign mch_ferr   = q.mferr;
    assign lvl_ferr   = q.lferr;
    assign len17      = q.l17;
    assign stop_vals  = q.stp;
    assign fr_manch   = q.f_manch;
    assign fr_len     = q.f_len;
endmodule

// File: rtl/mxrx_checker.sv
module mxrx_checker #(
    parameter int MAXB = 17,
    localparam int IDX_W = $clog2(MAXB + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd,
    input logic [MAXB-1:0]  rx_data,
    input logic             rx_done,
    input logic             rx_overrun,
    input logic             mch_ferr,
    input logic             lvl_ferr,
    input logic             len17,
    input logic [1:0]       stop_vals,
    input logic             fr_manch,
    input logic [IDX_W-1:0] fr_len
);
    // R10: a dropped frame implies a full buffer
    a_r10_ovr_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> rx_done);

    // R10: an unread buffer keeps its word
    a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !rd |=> $stable(rx_data));

    // R8: level frames leave the stop field alone
    a_r8_level_keeps_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) && !fr_manch |-> $stable(stop_vals));

    // R7, R6: Manchester-only flags stay clear for level frames
    a_r7_len_manch_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) && !fr_manch |-> !len17 && !mch_ferr);

    // R9: level stop error never reported for Manchester frames
    a_r9_lvl_ferr_level_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) && fr_manch |-> !lvl_ferr);

    // R2: bits above the word length are zero
    a_r2_word_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> ((rx_data >> fr_len) == '0));
endmodule

bind mxrx_receiver mxrx_checker #(.MAXB(MAXB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (rd),
    .rx_data   (rx_data),
    .rx_done   (rx_done),
    .rx_overrun(rx_overrun),
    .mch_ferr  (mch_ferr),
    .lvl_ferr  (lvl_ferr),
    .len17     (len17),
    .stop_vals (stop_vals),
    .fr_manch  (fr_manch),
    .fr_len    (fr_len)
);

// File: tb/mxrx_receiver_tb_top.sv
`timescale 1ns/1ps
module mxrx_receiver_tb_top;
    localparam int OSR  = 16;
    localparam int MAXB = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rxd = 1'b1;
    logic        manch_en = 1'b0;
    logic        msb_first = 1'b0;
    logic [4:0]  word_len = 5'd8;
    logic        rd = 1'b0;
    logic [16:0] rx_data;
    logic        rx_done, rx_overrun, mch_ferr, lvl_ferr, len17;
    logic [1:0]  stop_vals;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [16:0] e_data = '0;
    logic        e_done = 0, e_ovr = 0, e_mferr = 0, e_lferr = 0, e_l17 = 0;
    logic [1:0]  e_stp = '0;

    always #2.5 clk = ~clk;

    mxrx_receiver dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .manch_en(manch_en),
        .msb_first(msb_first), .word_len(word_len), .rd(rd),
        .rx_data(rx_data), .rx_done(rx_done), .rx_overrun(rx_overrun),
        .mch_ferr(mch_ferr), .lvl_ferr(lvl_ferr), .len17(len17),
        .stop_vals(stop_vals)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " R2/R4 data"}, 32'(rx_data), 32'(e_data));
        chk({tag, " R5 done"}, 32'(rx_done), 32'(e_done));
        chk({tag, " R10 overrun"}, 32'(rx_overrun), 32'(e_ovr));
        chk({tag, " R6 mch_ferr"}, 32'(mch_ferr), 32'(e_mferr));
        chk({tag, " R9 lvl_ferr"}, 32'(lvl_ferr), 32'(e_lferr));
        chk({tag, " R7 len17"}, 32'(len17), 32'(e_l17));
        chk({tag, " R8 stop_vals"}, 32'(stop_vals), 32'(e_stp));
    endtask

    function automatic logic [16:0] mask_word(logic [16:0] w, int n);
        return w & 17'((32'd1 << n) - 1);
    endfunction

    task automatic do_read(input string tag);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        e_done = 0;
        e_ovr = 0;
        chk({tag, " R5 read clears done"}, 32'(rx_done), 32'd0);
        chk({tag, " R5 read clears overrun"}, 32'(rx_overrun), 32'd0);
    endtask

    task automatic send(input logic [16:0] word, input int n, input bit msb, input bit manch,
                        input logic [1:0] stops, input int err_pos, input bit lstop,
                        input bit flip, input bit rd_after, input string tag);
        logic [19:0] bits;
        int nb;
        bit fresh;
        bits = '0;
        bits[0] = 1'b0;
        for (int i = 0; i < n; i++) bits[1+i] = msb ? word[n-1-i] : word[i];
        if (manch) begin
            bits[n+1] = stops[0];
            bits[n+2] = stops[1];
            nb = n + 3;
        end else begin
            bits[n+1] = lstop;
            nb = n + 2;
        end
        manch_en = manch;
        msb_first = msb;
        word_len = 5'(n);
        for (int b = 0; b < nb; b++) begin
            for (int s = 0; s < OSR; s++) begin
                if (manch && b != err_pos) rxd = (s < OSR/2) ? bits[b] : ~bits[b];
                else                       rxd = bits[b];
                if (flip && b == 1 && s == 0) begin
                    manch_en = ~manch;
                    msb_first = ~msb;
                    word_len = (n == 5) ? 5'd9 : 5'd5;
                end
                @(negedge clk);
            end
        end
        rxd = 1'b1;
        fresh = !e_done;
        @(negedge clk);
        if (fresh) chk({tag, " R5 done not early"}, 32'(rx_done), 32'd0);
        @(negedge clk);
        chk({tag, " R5 done on time"}, 32'(rx_done), 32'd1);
        if (fresh) begin
            e_done = 1;
            e_data = mask_word(word, n);
            e_mferr = manch && (err_pos >= 1);
            e_lferr = !manch && !lstop;
            e_l17 = manch && (n == MAXB);
            if (manch) e_stp = stops;
        end else begin
            e_ovr = 1;
        end
        chk_all(tag);
        if (rd_after) do_read(tag);
        repeat (2*OSR) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd5123;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");
        repeat (2*OSR) @(negedge clk);

        send(17'h000A5, 8, 0, 0, 2'b00, -1, 1, 0, 1, "R2 level lsb");
        send(17'h003C1, 10, 1, 0, 2'b00, -1, 1, 0, 1, "R4 level msb");
        send(17'h1ABCD, 17, 0, 0, 2'b00, -1, 1, 0, 1, "R2 level 17b");
        send(17'h0BEEF, 16, 0, 1, 2'b01, -1, 1, 0, 1, "R3 manch 16b");
        send(17'h1F00F, 17, 1, 1, 2'b10, -1, 1, 0, 1, "R7 manch 17b");
        send(17'h00055, 7, 0, 0, 2'b00, -1, 1, 0, 1, "R8 level keeps stop");
        send(17'h00123, 12, 0, 1, 2'b11, 3, 1, 0, 1, "R6 manch bad bit");
        send(17'h00033, 8, 0, 0, 2'b00, -1, 0, 0, 1, "R9 level low stop");
        send(17'h00011, 8, 0, 0, 2'b00, -1, 1, 0, 0, "R10 first");
        send(17'h000EE, 8, 0, 0, 2'b00, -1, 1, 0, 0, "R10 dropped");
        do_read("R10 release");

        manch_en = 1'b0;
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (4*OSR) @(negedge clk);
        chk("R11 level glitch rejected", 32'(rx_done), 32'd0);
        manch_en = 1'b1;
        rxd = 1'b0;
        repeat (OSR) @(negedge clk);
        rxd = 1'b1;
        repeat (4*OSR) @(negedge clk);
        chk("R11 manch bad start rejected", 32'(rx_done), 32'd0);

        send(17'h00B2C, 13, 0, 1, 2'b01, -1, 1, 1, 1, "R12 cfg change manch");
        send(17'h0002D, 6, 1, 0, 2'b00, -1, 1, 1, 1, "R12 cfg change level");

        for (int k = 0; k < 30; k++) begin
            logic [16:0] w;
            int n;
            bit m, o;
            logic [1:0] st;
            int ep;
            w = 17'($urandom());
            n = int'($urandom_range(17, 5));
            m = 1'($urandom_range(1, 0));
            o = 1'($urandom_range(1, 0));
            st = 2'($urandom_range(3, 0));
            ep = (m && $urandom_range(3, 0) == 0) ? int'($urandom_range(n + 2, 1)) : -1;
            send(w, n, o, m, st, ep, 1, 0, 1, "R3 random");
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule